// File: doc/BRIEF.md
# Decade Counter with One-Hot Decimal Decode

The block is a four-bit synchronous up-counter run as a modulo-ten state machine. Its count feeds a 4-to-16 decoder with active-low outputs, and the lower ten decoder lines are inverted into an active-high one-hot digit bus, so exactly one digit line is high per state. The counter can be loaded in parallel, cleared synchronously, gated by two count enables, and it exposes a carry for cascading stages.

The wrap is not a full compare against nine. Only the bits that are set in the terminal value (bits 3 and 0 for a modulus of ten) are combined in an active-low NAND term. That term shares the load path with an external active-low load request. When the counter sits at a state with both bits set, the next edge reloads the parallel value. That value is normally zero, and any other value makes the restart point programmable. Because the decode is partial, a counter forced into 10, 12 or 14 steps once more before it restarts, and no digit line is high while it is out of the decimal range.

Top module: `decade_onehot_counter`

## Requirements
- R1: While `rst` is high at a rising edge, `count` becomes 0 on that edge.
- R2: With `clr_n`, `ld_n` high and the count not terminal, `count` increments by one on each edge where `en_p` and `en_t` are both high, and holds if either is low.
- R3: When `count[3]` and `count[0]` are both 1 (states 9, 11, 13, 15), the next edge loads `ld_val` into `count` whatever `en_p` and `en_t` are; with `ld_val` = 0 the sequence is 0..9,0, and a nonzero `ld_val` becomes the restart point.
- R4: `ld_n` low loads `ld_val` on the next edge regardless of the enables, taking priority over counting.
- R5: `clr_n` low sets `count` to 0 on the next edge, taking priority over any load.
- R6: `carry` is 1 exactly when `count` is 15 and `en_t` is 1.
- R7: With `dec_g1_n` and `dec_g2_n` both 0, `dec_n` has only bit index `count` at 0; if either enable is 1, all sixteen bits of `dec_n` are 1.
- R8: `digit[k]` (k = 0..9) is the inverse of `dec_n[k]`, so one bit is high for counts 0 to 9 and none for counts 10 to 15 or while the decoder is disabled.
- R9: A count forced to 10, 12 or 14 advances to 11, 13 or 15 and then restarts at `ld_val` on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clr_n | input | 1 | Synchronous clear, active low |
| ld_n | input | 1 | External parallel load request, active low |
| ld_val | input | 4 | Parallel value for loads and for the restart |
| en_p | input | 1 | Parallel count enable, active high |
| en_t | input | 1 | Trickle count enable, also gates carry |
| dec_g1_n | input | 1 | Decoder enable 1, active low |
| dec_g2_n | input | 1 | Decoder enable 2, active low |
| count | output | 4 | Registered counter state |
| carry | output | 1 | Ripple carry for cascading |
| dec_n | output | 16 | Active-low one-cold decoder outputs |
| digit | output | 10 | Active-high one-hot decimal lines |

## Verification
The bench builds the block with its defaults: a four-bit counter and a modulus of ten, giving the terminal mask 1001. At that width the external load reaches all sixteen states, so the bench also covers the out-of-range states 10 to 15. There it checks the extra step the partial decode allows, the carry at 15 (the only state where it can rise), and the silent digit bus. A nonzero parallel value shows the restart point moving.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  // Next-state selection of the loadable counter, highest priority first.
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } cnt_act_e;

  function automatic cnt_act_e pick_action(
    input logic clr_n,
    input logic ld_n,
    input logic en_p,
    input logic en_t
  );
    if (!clr_n)            return ACT_CLEAR;
    else if (!ld_n)        return ACT_LOAD;
    else if (en_p && en_t) return ACT_COUNT;
    else                   return ACT_HOLD;
  endfunction

endpackage

// File: rtl/dcd_counter.sv
module dcd_counter
  import dcd_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic [W-1:0] ld_val,
  input  logic         en_p,
  input  logic         en_t,
  output logic [W-1:0] q,
  output logic         rco
);

  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  cnt_act_e act;

  always_comb begin
    act = pick_action(clr_n, ld_n, en_p, en_t);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= ZERO;
    end else begin
      case (act)
        ACT_CLEAR: q <= ZERO;
        ACT_LOAD:  q <= ld_val;
        ACT_COUNT: q <= q + ONE;
        default:   q <= q;
      endcase
    end
  end

  // Carry marks the all-ones state, gated by the trickle enable.
  assign rco = en_t & (&q);

endmodule

// File: rtl/dcd_terminal.sv
module dcd_terminal #(
  parameter int           W    = 4,
  parameter logic [W-1:0] MASK = 4'b1001
) (
  input  logic [W-1:0] q,
  output logic         term_n
);

  // Partial decode: only the bits set in MASK take part, the rest are forced true.
  logic [W-1:0] masked;

  always_comb begin
    masked = q | ~MASK;
    term_n = ~(&masked);
  end

endmodule

// File: rtl/dcd_decoder.sv
module dcd_decoder #(
  parameter int W = 4,
  parameter int N = 1 << W
) (
  input  logic [W-1:0] sel,
  input  logic         g1_n,
  input  logic         g2_n,
  output logic [N-1:0] y_n
);

  logic en;
  assign en = ~g1_n & ~g2_n;

  for (genvar i = 0; i < N; i++) begin : g_line
    assign y_n[i] = ~(en && (sel == W'(i)));
  end

endmodule

// File: rtl/decade_onehot_counter.sv
module decade_onehot_counter #(
  parameter int CNT_W   = 4,
  parameter int MODULUS = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_n,
  input  logic                  ld_n,
  input  logic [CNT_W-1:0]      ld_val,
  input  logic                  en_p,
  input  logic                  en_t,
  input  logic                  dec_g1_n,
  input  logic                  dec_g2_n,
  output logic [CNT_W-1:0]      count,
  output logic                  carry,
  output logic [(1<<CNT_W)-1:0] dec_n,
  output logic [MODULUS-1:0]    digit
);

  localparam int           DEC_N     = 1 << CNT_W;
  localparam logic [CNT_W-1:0] TERM_MASK = CNT_W'(MODULUS - 1);

  logic term_n;
  logic load_n_all;

  dcd_terminal #(
    .W    (CNT_W),
    .MASK (TERM_MASK)
  ) u_term (
    .q      (count),
    .term_n (term_n)
  );

  // Both load sources are active low and share one wired-AND load line.
  assign load_n_all = ld_n & term_n;

  dcd_counter #(
    .W (CNT_W)
  ) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr_n  (clr_n),
    .ld_n   (load_n_all),
    .ld_val (ld_val),
    .en_p   (en_p),
    .en_t   (en_t),
    .q      (count),
    .rco    (carry)
  );

  dcd_decoder #(
    .W (CNT_W),
    .N (DEC_N)
  ) u_dec (
    .sel  (count),
    .g1_n (dec_g1_n),
    .g2_n (dec_g2_n),
    .y_n  (dec_n)
  );

  for (genvar k = 0; k < MODULUS; k++) begin : g_digit
    assign digit[k] = ~dec_n[k];
  end

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
  parameter int CNT_W   = 4,
  parameter int MODULUS = 10
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  clr_n,
  input logic                  ld_n,
  input logic [CNT_W-1:0]      ld_val,
  input logic                  en_p,
  input logic                  en_t,
  input logic                  dec_g1_n,
  input logic                  dec_g2_n,
  input logic [CNT_W-1:0]      count,
  input logic                  carry,
  input logic [(1<<CNT_W)-1:0] dec_n,
  input logic [MODULUS-1:0]    digit
);

  localparam logic [CNT_W-1:0] MASK = CNT_W'(MODULUS - 1);

  logic at_term;
  assign at_term = ((count & MASK) == MASK);

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> count == '0);

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> count == '0);

  // R3
  wrap_load_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && at_term) |=> count == $past(ld_val));

  // R4
  ext_load_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !ld_n) |=> count == $past(ld_val));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && !at_term && en_p && en_t) |=> count == CNT_W'($past(count) + 1'b1));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_n && ld_n && !at_term && !(en_p && en_t)) |=> $stable(count));

  // R6
  carry_state_chk: assert property (@(posedge clk) disable iff (rst)
    carry |-> (&count) && en_t);

  // R7
  dec_cold_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~dec_n));

  // R8
  digit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (digit != '0) |-> ($countones(digit) == 1 && count < CNT_W'(MODULUS)));

endmodule

bind decade_onehot_counter dcd_checker #(
  .CNT_W   (CNT_W),
  .MODULUS (MODULUS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clr_n    (clr_n),
  .ld_n     (ld_n),
  .ld_val   (ld_val),
  .en_p     (en_p),
  .en_t     (en_t),
  .dec_g1_n (dec_g1_n),
  .dec_g2_n (dec_g2_n),
  .count    (count),
  .carry    (carry),
  .dec_n    (dec_n),
  .digit    (digit)
);

// File: tb/decade_onehot_counter_tb.sv
`timescale 1ns/1ps
module decade_onehot_counter_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        clr_n, ld_n, en_p, en_t, dec_g1_n, dec_g2_n;
  logic [3:0]  ld_val;
  logic [3:0]  count;
  logic        carry;
  logic [15:0] dec_n;
  logic [9:0]  digit;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  decade_onehot_counter u_dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .ld_n(ld_n), .ld_val(ld_val),
    .en_p(en_p), .en_t(en_t), .dec_g1_n(dec_g1_n), .dec_g2_n(dec_g2_n),
    .count(count), .carry(carry), .dec_n(dec_n), .digit(digit)
  );

  // Vector: {clr_n, ld_n, ld_val[3:0], en_p, en_t, expected count[3:0]}
  localparam int NV = 29;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd1 },  // R2 count
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd2 },
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd3 },
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd4 },
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd5 },
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd6 },
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd7 },
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd8 },
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd9 },
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd0 },  // R3 wrap 9 -> 0
    {1'b1,1'b1,4'd0 ,1'b0,1'b1,4'd0 },  // R2 hold, en_p low
    {1'b1,1'b1,4'd0 ,1'b1,1'b0,4'd0 },  // R2 hold, en_t low
    {1'b1,1'b0,4'd5 ,1'b0,1'b0,4'd5 },  // R4 load with enables low
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd6 },
    {1'b0,1'b0,4'd7 ,1'b1,1'b1,4'd0 },  // R5 clear beats load
    {1'b1,1'b0,4'd12,1'b1,1'b1,4'd12},  // R9 force 12
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd13},
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd0 },
    {1'b1,1'b0,4'd14,1'b1,1'b1,4'd14},  // R9 force 14
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd15},  // R6 carry at 15
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd0 },
    {1'b1,1'b0,4'd10,1'b1,1'b1,4'd10},  // R9 force 10
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd11},
    {1'b1,1'b1,4'd0 ,1'b1,1'b1,4'd0 },
    {1'b1,1'b0,4'd8 ,1'b1,1'b1,4'd8 },
    {1'b1,1'b1,4'd3 ,1'b1,1'b1,4'd9 },  // ld_val ignored off terminal
    {1'b1,1'b1,4'd3 ,1'b1,1'b1,4'd3 },  // R3 programmable restart
    {1'b1,1'b0,4'd9 ,1'b1,1'b1,4'd9 },
    {1'b1,1'b1,4'd0 ,1'b0,1'b0,4'd0 }   // R3 wrap with enables low
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_decn(input logic [3:0] c, input logic en);
    return en ? ~(16'd1 << c) : 16'hFFFF;
  endfunction

  function automatic logic [9:0] exp_digit(input logic [3:0] c, input logic en);
    return (en && c < 4'd10) ? (10'd1 << c) : 10'd0;
  endfunction

  task automatic check_outputs(input string tag, input logic [3:0] ec, input logic et, input logic den);
    check({tag, " R1/R2/R3/R4/R5/R9 count"}, 16'(count), 16'(ec));
    check({tag, " R6 carry"}, 16'(carry), 16'((ec == 4'd15) && et));
    check({tag, " R7 dec_n"}, dec_n, exp_decn(ec, den));
    check({tag, " R8 digit"}, 16'(digit), 16'(exp_digit(ec, den)));
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; clr_n = 1'b1; ld_n = 1'b1; ld_val = 4'd0;
    en_p = 1'b1; en_t = 1'b1; dec_g1_n = 1'b0; dec_g2_n = 1'b0;
    repeat (3) tick();
    // R1 reset state
    check_outputs("reset", 4'd0, 1'b1, 1'b1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {clr_n, ld_n, ld_val, en_p, en_t} = VEC[i][11:4];
      tick();
      check_outputs($sformatf("vec %0d", i), VEC[i][3:0], en_t, 1'b1);
    end

    // R7 R8 decoder disable through either enable
    clr_n = 1'b1; ld_n = 1'b0; ld_val = 4'd4; en_p = 1'b0; en_t = 1'b0;
    tick();
    ld_n = 1'b1;
    dec_g1_n = 1'b1;
    #1 check_outputs("g1 off", 4'd4, 1'b0, 1'b0);
    dec_g1_n = 1'b0; dec_g2_n = 1'b1;
    #1 check_outputs("g2 off", 4'd4, 1'b0, 1'b0);
    dec_g2_n = 1'b0;
    #1 check_outputs("dec on", 4'd4, 1'b0, 1'b1);

    // R6 carry needs en_t at 15
    ld_n = 1'b0; ld_val = 4'd15;
    tick();
    ld_n = 1'b1; en_t = 1'b0; en_p = 1'b0;
    #1 check_outputs("R6 no en_t", 4'd15, 1'b0, 1'b1);

    // R1 reset mid-count beats a pending load
    ld_n = 1'b0; ld_val = 4'd6; tick();
    ld_n = 1'b0; ld_val = 4'd2; rst = 1'b1; tick();
    rst = 1'b0; ld_n = 1'b1;
    check_outputs("R1 mid reset", 4'd0, 1'b0, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule